// File: doc/BRIEF.md
# Critical-Word-First Line Fill Buffer

This block sits between a data cache and the bus interface that returns refill data. When a load misses, the cache hands the block a fill request: the line address and the index of the 64-bit word the load is waiting for. The refill then arrives as four beats, possibly with idle cycles between them, and the requested word comes first. That first beat is forwarded at once so the stalled load can finish. The pipeline is told it may restart as soon as that word is in and no other miss is queued, even though the rest of the line is still on its way.

The later beats fill the remaining word slots of a holding latch in wrap order. Loads that hit the pending line can read any word that has already arrived straight from the latch. Once the fourth beat is stored, the block waits for a cycle in which the cache data array is not in use by a load or a store. In that cycle it writes the whole line in one transfer. Until that write happens, the block refuses any new fill request.

Request and beat inputs use valid/ready. A request transfers on a cycle with `req_valid` and `req_ready` both high. A beat transfers on a cycle with `beat_valid` and `beat_ready` both high. Neither side may assume a transfer on any other cycle. The forwarded word, the resume flag and the array write port have no back-pressure: the receiver must take them in the cycle they are shown.

Top module: `fill_buffer`

## Requirements
- R1: After reset, `req_ready` is 1, and `beat_ready`, `fwd_valid`, `resume`, `arr_wr_en` and `ld_hit` are all 0.
- R2: A request is taken only on a cycle with `req_valid` and `req_ready` both high. `req_ready` falls in the cycle after the request is taken and stays 0 until the cycle after the line is written to the array.
- R3: `beat_ready` is 1 only while beats are being collected. Beat k of a fill (k = 0..3) is stored in word slot (requested index + k) mod 4. Any number of idle cycles may separate beats.
- R4: In the cycle after the first beat is taken, `fwd_valid` is 1 for exactly one cycle and `fwd_data` equals that beat's data.
- R5: `resume` is 1 exactly when the requested word of the pending fill has arrived and `missq_empty` is 1. This holds from the cycle after the first beat until the line write, and `resume` is 0 when no fill is pending.
- R6: `arr_wr_en` is 1 for one cycle per fill, only after all four beats are stored. On that cycle `arr_wr_line` is the requested line and word slot i appears at `arr_wr_data[i*64 +: 64]`.
- R7: While `array_busy` is 1, `arr_wr_en` stays 0 and the completed line is held. The write happens on the first cycle `array_busy` is 0.
- R8: `ld_hit` is 1 only when `ld_valid` is 1, a fill is pending, `ld_line` equals its line, and word `ld_word` has already arrived. `ld_data` is then that word. Once the line has been written, the latch no longer hits.
- R9: `beat_valid` while no fill is collecting is ignored: that data never reaches the line that is written.
- R10: `req_valid` while a fill is pending is ignored: the pending line address written to the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fill request valid |
| req_ready | output | 1 | Block can take a fill request |
| req_line | input | LINE_W | Line address of the fill |
| req_word | input | 2 | Index of the word the load waits for |
| beat_valid | input | 1 | Refill beat valid |
| beat_ready | output | 1 | Block is collecting beats |
| beat_data | input | DATA_W | Refill beat data |
| array_busy | input | 1 | Data array used by a load or store this cycle |
| missq_empty | input | 1 | No further load miss is queued |
| ld_valid | input | 1 | Load lookup valid |
| ld_line | input | LINE_W | Line address of the load |
| ld_word | input | 2 | Word index of the load |
| ld_hit | output | 1 | Load served from the pending latch |
| ld_data | output | DATA_W | Word read from the latch |
| fwd_valid | output | 1 | Requested word forwarded this cycle |
| fwd_data | output | DATA_W | Forwarded requested word |
| resume | output | 1 | Pipeline may restart |
| arr_wr_en | output | 1 | Write whole line to the data array |
| arr_wr_line | output | LINE_W | Line address of the array write |
| arr_wr_data | output | 4*DATA_W | Line data, slot i in bits i*64 upward |

## Verification
The assertions assume that the bus side returns exactly four beats after each accepted request and never a fifth. They also assume that only one request is in flight. As a result, no word slot is written twice and the line is full whenever the array write fires. The stimulus accepts one request at a time and offers exactly four beats per fill, spaced by chosen idle gaps. Stray beats and stray requests are offered only while the block is not ready for them, and the design must ignore those. `array_busy` and `missq_empty` are driven freely, because the block has to cope with any value of either.

// File: rtl/fill_pkg.sv
`timescale 1ns/1ps
package fill_pkg;
  typedef enum logic [1:0] {
    FS_IDLE    = 2'd0,
    FS_COLLECT = 2'd1,
    FS_DRAIN   = 2'd2
  } fill_state_e;
endpackage

// File: rtl/fill_ctrl.sv
`timescale 1ns/1ps
module fill_ctrl
  import fill_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int IDX_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic [IDX_W-1:0] req_word,
  input  logic             beat_valid,
  input  logic             array_busy,
  output fill_state_e      state,
  output logic             beat_fire,
  output logic             first_beat,
  output logic [IDX_W-1:0] slot_idx,
  output logic [IDX_W-1:0] crit_idx,
  output logic             crit_seen,
  output logic             arr_wr_en
);
  localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(BEATS - 1);

  fill_state_e      state_q;
  logic [IDX_W-1:0] cnt_q;
  logic [IDX_W-1:0] crit_q;

  assign state      = state_q;
  assign crit_idx   = crit_q;
  assign beat_fire  = (state_q == FS_COLLECT) && beat_valid;
  assign first_beat = (cnt_q == '0);
  assign slot_idx   = crit_q + cnt_q;
  assign crit_seen  = ((state_q == FS_COLLECT) && (cnt_q != '0)) || (state_q == FS_DRAIN);
  assign arr_wr_en  = (state_q == FS_DRAIN) && !array_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      cnt_q   <= '0;
      crit_q  <= '0;
    end else begin
      unique case (state_q)
        FS_IDLE: if (req_fire) begin
          state_q <= FS_COLLECT;
          cnt_q   <= '0;
          crit_q  <= req_word;
        end
        FS_COLLECT: if (beat_valid) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_BEAT) state_q <= FS_DRAIN;
        end
        FS_DRAIN: if (!array_busy) state_q <= FS_IDLE;
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  // R2: the request side reopens right after the line write
  assert_ready_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |=> (state_q == FS_IDLE));

  // R7: a busy array keeps the completed line parked
  assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == FS_DRAIN) && array_busy) |=> (state_q == FS_DRAIN) && !$past(arr_wr_en));
endmodule

// File: rtl/fill_latch.sv
`timescale 1ns/1ps
module fill_latch #(
  parameter int BEATS  = 4,
  parameter int DATA_W = 64,
  parameter int LINE_W = 26,
  parameter int IDX_W  = $clog2(BEATS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_fire,
  input  logic [LINE_W-1:0]       req_line,
  input  logic                    slot_we,
  input  logic [IDX_W-1:0]        slot_idx,
  input  logic [DATA_W-1:0]       beat_data,
  input  logic                    pending,
  input  logic                    line_wr,
  input  logic                    ld_valid,
  input  logic [LINE_W-1:0]       ld_line,
  input  logic [IDX_W-1:0]        ld_word,
  output logic [LINE_W-1:0]       line_addr,
  output logic [BEATS*DATA_W-1:0] line_data,
  output logic [BEATS-1:0]        filled,
  output logic                    ld_hit,
  output logic [DATA_W-1:0]       ld_data
);
  logic [LINE_W-1:0] line_q;
  logic [BEATS-1:0]  filled_q;
  logic [DATA_W-1:0] slot_q [BEATS];

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= '0;
    else if (req_fire) line_q <= req_line;
  end

  for (genvar i = 0; i < BEATS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) filled_q[i] <= 1'b0;
      else if (req_fire) filled_q[i] <= 1'b0;
      else if (slot_we && (slot_idx == IDX_W'(i))) filled_q[i] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (slot_we && (slot_idx == IDX_W'(i))) slot_q[i] <= beat_data;
    end
    assign line_data[i*DATA_W +: DATA_W] = slot_q[i];
  end

  assign line_addr = line_q;
  assign filled    = filled_q;
  assign ld_hit    = ld_valid && pending && (ld_line == line_q) && filled_q[ld_word];
  assign ld_data   = slot_q[ld_word];

  // R3: each word slot takes exactly one beat per fill
  assert_slot_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_we |-> !filled_q[slot_idx]);

  // R6: the array write only ever carries a complete line
  assert_line_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_wr |-> (&filled_q));
endmodule

// File: rtl/fill_buffer.sv
`timescale 1ns/1ps
module fill_buffer
  import fill_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  parameter int IDX_W  = $clog2(BEATS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LINE_W-1:0]       req_line,
  input  logic [IDX_W-1:0]        req_word,
  input  logic                    beat_valid,
  output logic                    beat_ready,
  input  logic [DATA_W-1:0]       beat_data,
  input  logic                    array_busy,
  input  logic                    missq_empty,
  input  logic                    ld_valid,
  input  logic [LINE_W-1:0]       ld_line,
  input  logic [IDX_W-1:0]        ld_word,
  output logic                    ld_hit,
  output logic [DATA_W-1:0]       ld_data,
  output logic                    fwd_valid,
  output logic [DATA_W-1:0]       fwd_data,
  output logic                    resume,
  output logic                    arr_wr_en,
  output logic [LINE_W-1:0]       arr_wr_line,
  output logic [BEATS*DATA_W-1:0] arr_wr_data
);
  fill_state_e      state;
  logic             req_fire, beat_fire, first_beat, crit_seen;
  logic [IDX_W-1:0] slot_idx, crit_idx;
  logic [BEATS-1:0] filled;
  logic             fwd_v_q;
  logic [DATA_W-1:0] fwd_d_q;

  assign req_ready  = (state == FS_IDLE);
  assign beat_ready = (state == FS_COLLECT);
  assign req_fire   = req_valid && req_ready;

  fill_ctrl #(.BEATS(BEATS), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_fire   (req_fire),
    .req_word   (req_word),
    .beat_valid (beat_valid),
    .array_busy (array_busy),
    .state      (state),
    .beat_fire  (beat_fire),
    .first_beat (first_beat),
    .slot_idx   (slot_idx),
    .crit_idx   (crit_idx),
    .crit_seen  (crit_seen),
    .arr_wr_en  (arr_wr_en)
  );

  fill_latch #(.BEATS(BEATS), .DATA_W(DATA_W), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (req_fire),
    .req_line  (req_line),
    .slot_we   (beat_fire),
    .slot_idx  (slot_idx),
    .beat_data (beat_data),
    .pending   (state != FS_IDLE),
    .line_wr   (arr_wr_en),
    .ld_valid  (ld_valid),
    .ld_line   (ld_line),
    .ld_word   (ld_word),
    .line_addr (arr_wr_line),
    .line_data (arr_wr_data),
    .filled    (filled),
    .ld_hit    (ld_hit),
    .ld_data   (ld_data)
  );

  // critical word goes out one cycle after its beat lands
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_v_q <= 1'b0;
      fwd_d_q <= '0;
    end else begin
      fwd_v_q <= beat_fire && first_beat;
      if (beat_fire && first_beat) fwd_d_q <= beat_data;
    end
  end

  assign fwd_valid = fwd_v_q;
  assign fwd_data  = fwd_d_q;
  assign resume    = crit_seen && missq_empty;

  // R4: a forwarded word is the beat taken one cycle earlier
  assert_fwd_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> ($past(beat_valid && beat_ready) && (fwd_data == $past(beat_data))));

  // R5: resume never precedes the requested word in the latch
  assert_resume_has_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> filled[crit_idx]);

  // R6: the line write never collides with array use
  assert_write_when_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |-> !array_busy && !req_ready);
endmodule

// File: tb/tb_fill_buffer.sv
`timescale 1ns/1ps
module tb_fill_buffer;
  localparam int LW = 26;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, beat_valid = 0, array_busy = 0, missq_empty = 1, ld_valid = 0;
  logic [LW-1:0] req_line = '0, ld_line = '0;
  logic [1:0] req_word = '0, ld_word = '0;
  logic [DW-1:0] beat_data = '0;
  logic req_ready, beat_ready, ld_hit, fwd_valid, resume, arr_wr_en;
  logic [DW-1:0] ld_data, fwd_data;
  logic [LW-1:0] arr_wr_line;
  logic [4*DW-1:0] arr_wr_data;

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [DW-1:0]   exp_fwd[$];
  logic [LW-1:0]   exp_line[$];
  logic [4*DW-1:0] exp_data[$];

  always #4 clk = ~clk;

  fill_buffer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .req_word(req_word), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .beat_data(beat_data), .array_busy(array_busy),
    .missq_empty(missq_empty), .ld_valid(ld_valid), .ld_line(ld_line),
    .ld_word(ld_word), .ld_hit(ld_hit), .ld_data(ld_data), .fwd_valid(fwd_valid),
    .fwd_data(fwd_data), .resume(resume), .arr_wr_en(arr_wr_en),
    .arr_wr_line(arr_wr_line), .arr_wr_data(arr_wr_data)
  );

  task automatic chk(input bit ok, input string req, input logic [4*DW-1:0] act,
                     input logic [4*DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(input logic [LW-1:0] line, input int slot);
    return 64'hC0DE_0000_0000_0000 ^ (64'(line) << 16) ^ 64'(slot);
  endfunction

  // scoreboard monitor: forwarded words and array writes
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && fwd_valid) begin
        if (exp_fwd.size() == 0) chk(0, "R4 unexpected forward", fwd_data, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_fwd.pop_front();
          chk(fwd_data == e, "R4 forwarded word", fwd_data, e);
        end
      end
      if (rst_n && arr_wr_en) begin
        if (exp_line.size() == 0) chk(0, "R6 unexpected array write", arr_wr_line, 0);
        else begin
          logic [LW-1:0] el;
          logic [4*DW-1:0] ed;
          el = exp_line.pop_front();
          ed = exp_data.pop_front();
          chk(arr_wr_line == el, "R6 R10 write line", arr_wr_line, el);
          chk(arr_wr_data == ed, "R6 R3 R9 write data", arr_wr_data, ed);
        end
      end
    end
  end

  task automatic do_fill(input logic [LW-1:0] line, input logic [1:0] crit,
                         input int gap, input int busy, input bit mq, input bit stray);
    logic [4*DW-1:0] ld;
    for (int i = 0; i < 4; i++) ld[i*DW +: DW] = mk(line, i);
    exp_fwd.push_back(mk(line, int'(crit)));
    exp_line.push_back(line);
    exp_data.push_back(ld);
    missq_empty = mq;
    @(posedge clk) #1;
    req_valid = 1; req_line = line; req_word = crit;
    @(negedge clk);
    chk(req_ready == 1, "R2 ready when idle", req_ready, 1);
    @(posedge clk) #1;
    req_valid = stray; req_line = line ^ 26'h155; req_word = ~crit;
    @(negedge clk);
    chk(req_ready == 0 && beat_ready == 1, "R2 R3 collecting", {req_ready, beat_ready}, 2'b01);
    if (stray) chk(req_ready == 0, "R10 stray request refused", req_ready, 0);
    @(posedge clk) #1;
    for (int k = 0; k < 4; k++) begin
      logic [1:0] s;
      s = 2'(crit + 2'(k));
      beat_valid = 0;
      repeat (gap) @(posedge clk) #1;
      beat_valid = 1; beat_data = mk(line, int'(s));
      if (k == 3 && busy > 0) array_busy = 1;
      if (k == 0) begin ld_valid = 1; ld_line = line; ld_word = crit; end
      @(posedge clk) #1;
      beat_valid = 0;
      if (k == 0) begin
        @(negedge clk);
        chk(fwd_valid == 1, "R4 forward one cycle after first beat", fwd_valid, 1);
        chk(resume == mq, "R5 resume follows miss queue", resume, mq);
        chk(ld_hit == 1 && ld_data == mk(line, int'(crit)), "R8 hit on arrived word",
            {ld_hit, ld_data}, {1'b1, mk(line, int'(crit))});
        ld_word = crit + 2'd1; #1;
        chk(ld_hit == 0, "R8 miss on word not yet arrived", ld_hit, 0);
        ld_word = crit; ld_line = line ^ 26'h1; #1;
        chk(ld_hit == 0, "R8 miss on other line", ld_hit, 0);
        ld_valid = 0;
        if (!mq) begin
          missq_empty = 1; #1;
          chk(resume == 1, "R5 resume once miss queue drains", resume, 1);
        end
        @(posedge clk) #1;
      end
    end
    req_valid = 0;
    for (int b = 0; b < busy; b++) begin
      @(negedge clk);
      chk(arr_wr_en == 0 && req_ready == 0, "R7 write held while array busy",
          {arr_wr_en, req_ready}, 0);
      @(posedge clk) #1;
    end
    array_busy = 0;
    @(posedge clk) #1;
    ld_valid = 1; ld_line = line; ld_word = crit;
    @(negedge clk);
    chk(req_ready == 1 && resume == 0 && arr_wr_en == 0, "R2 R5 R6 idle after write",
        {req_ready, resume, arr_wr_en}, 3'b100);
    chk(ld_hit == 0, "R8 no hit after line written", ld_hit, 0);
    ld_valid = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && beat_ready == 0 && fwd_valid == 0 && resume == 0 &&
        arr_wr_en == 0 && ld_hit == 0, "R1 reset state",
        {req_ready, beat_ready, fwd_valid, resume, arr_wr_en, ld_hit}, 6'b100000);
    do_fill(26'h0001234, 2'd0, 0, 0, 1, 0);
    do_fill(26'h2ABCDEF, 2'd2, 2, 3, 0, 0);
    // R9: beats offered while idle must be dropped
    @(posedge clk) #1;
    beat_valid = 1; beat_data = 64'hDEAD_BEEF_DEAD_BEEF;
    @(negedge clk);
    chk(beat_ready == 0, "R9 no beat taken while idle", beat_ready, 0);
    @(posedge clk) #1;
    @(posedge clk) #1;
    beat_valid = 0;
    do_fill(26'h1555555, 2'd3, 1, 0, 1, 1);
    do_fill(26'h0F0F0F0, 2'd1, 3, 1, 1, 0);
    do_fill(26'h3FFFFFF, 2'd2, 0, 2, 0, 1);
    repeat (3) @(posedge clk);
    chk(exp_fwd.size() == 0 && exp_line.size() == 0, "R4 R6 scoreboard drained",
        exp_fwd.size() + exp_line.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule